// File: doc/BRIEF.md
# Key-Hash Presence Filter

This block sits in the forwarding path of a switch that has a key-value accelerator attached to it. It records which 32-bit key hashes the accelerator currently caches. Every packet offers a lookup. For an in-network GET request, the block replaces the destination MAC address with a synthetic one: a fixed locally administered 16-bit prefix in the upper bits, followed by the key hash. It also says whether the packet should be steered to the accelerator (hit) or sent on toward the server (miss). Other packets pass through with their address unchanged, in the same cycle, with no register in their path.

The table is set-associative. The low hash bits select a set, and each way stores a full hash tag and a reference count. The accelerator issues an insert command once it has finished handling a GET reply. It issues a remove command once it has acknowledged an invalidation. Because two cached keys can share a hash, an entry is freed only when its count returns to zero. A false hit caused by such a collision is acceptable, because the accelerator then forwards the request itself. When a set is full, an insert is refused and reported; nothing is evicted. Each command returns a status code one cycle later.

Top module: `keyhash_presence_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, every lookup misses and `st_valid` is 0.
- R2: For a lookup with `lk_in_net`=1, `lk_out_mac` equals `{MAC_PREFIX, lk_hash}` (prefix in bits 47:32, hash in bits 31:0) in the same cycle.
- R3: For a lookup with `lk_in_net`=0, `lk_out_mac` equals `lk_dst_mac` and `lk_to_accel` is 0 in the same cycle, whatever the table holds.
- R4: With `lk_in_net`=1, `lk_to_accel` is 1 in the same cycle exactly when the table holds a live entry whose full tag equals `lk_hash`.
- R5: An insert (`upd_op`=0) of a hash that is absent, into a set with a free way, creates an entry with count 1 and reports status 0 (accepted).
- R6: An insert of a present hash raises its count by one, and a remove (`upd_op`=1) lowers it by one. The entry stays visible to lookups until its count reaches zero.
- R7: An insert of an absent hash into a set whose ways are all live is refused with status 1 (set full). Every existing entry is left unchanged.
- R8: An insert of a hash whose count is already at its maximum (2^CNT_W-1) reports status 2 (count saturated) and leaves the count unchanged.
- R9: A remove of a hash that is absent reports status 3 (not present) and changes nothing.
- R10: A lookup made in the same cycle as an insert or remove of the same hash sees the table as it was before that command.
- R11: The set is chosen by hash bits log2(SETS)-1:0. Each set holds at most WAYS live entries, independently of the other sets.
- R12: `st_valid` is 1 exactly in the cycle after a cycle with `upd_valid`=1, and `st_code` then carries that command's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_in_net | input | 1 | Current packet is an in-network GET request |
| lk_hash | input | HASH_W | Key hash carried by the packet |
| lk_dst_mac | input | MAC_W | Original destination MAC address |
| lk_out_mac | output | MAC_W | Destination MAC address after rewrite |
| lk_to_accel | output | 1 | Steer the packet to the accelerator port |
| upd_valid | input | 1 | Table command present |
| upd_op | input | 1 | 0 = insert, 1 = remove |
| upd_hash | input | HASH_W | Hash that the command applies to |
| st_valid | output | 1 | Status of the previous cycle's command is valid |
| st_code | output | 2 | 0 accepted, 1 set full, 2 count saturated, 3 not present |

## Verification
The assertions assume that at most one command arrives per cycle, and that `upd_op` and `upd_hash` are stable whenever `upd_valid` is high. They also assume that SETS is a power of two, so that the set index is exactly the low hash bits. The bench drives every command and every lookup on the falling clock edge. It issues a single command per cycle and releases `upd_valid` before the next one. It uses a small configuration (4 sets, 2 ways, 2-bit counts) and hashes below 64, so a plain per-hash count array in the bench can predict fills, refusals, saturation and frees.

// File: rtl/kpf_pkg.sv
// Shared types for the key-hash presence filter.
// Assumes: command and status encodings are fixed by the block's interface.
package kpf_pkg;
    typedef enum logic {
        OP_INSERT = 1'b0,
        OP_REMOVE = 1'b1
    } kpf_op_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_FULL   = 2'd1,
        ST_SAT    = 2'd2,
        ST_ABSENT = 2'd3
    } kpf_status_e;
endpackage

// File: rtl/kpf_set_probe.sv
// Compares one key against every way of a single set.
// Assumes: a way is live when its count is non-zero; the tag is the full hash.
module kpf_set_probe #(
    parameter int WAYS   = 4,
    parameter int HASH_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic [WAYS-1:0][HASH_W-1:0] tags,
    input  logic [WAYS-1:0][CNT_W-1:0]  cnts,
    input  logic [HASH_W-1:0]           key,
    output logic [WAYS-1:0]             match_vec,
    output logic                        hit
);
    // per-way comparators, one per way
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match_vec[w] = (cnts[w] != '0) && (tags[w] == key);
    end

    // any live way holding the key
    assign hit = |match_vec;
endmodule

// File: rtl/kpf_table.sv
// Set-associative store of reference-counted hash tags.
// Lookup is combinational on the registered state, so it sees pre-update contents.
// Assumes: SETS is a power of two; at most one command per cycle.
module kpf_table
    import kpf_pkg::*;
#(
    parameter int SETS   = 256,
    parameter int WAYS   = 4,
    parameter int HASH_W = 32,
    parameter int CNT_W  = 4,
    parameter int SET_W  = $clog2(SETS),
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HASH_W-1:0] lk_hash,
    output logic              lk_hit,
    input  logic              upd_valid,
    input  logic              upd_op,
    input  logic [HASH_W-1:0] upd_hash,
    output logic              st_valid,
    output logic [1:0]        st_code
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WAYS-1:0][HASH_W-1:0] tag_q [SETS];
    logic [WAYS-1:0][CNT_W-1:0]  cnt_q [SETS];

    logic [SET_W-1:0] lk_set, u_set;
    logic [WAYS-1:0]  lk_match_vec, u_match_vec;
    logic             u_hit, u_free;
    logic [WAY_W-1:0] u_hit_way, u_free_way;
    logic [CNT_W-1:0] u_hit_cnt;

    logic             wr_en, wr_new;
    logic [WAY_W-1:0] wr_way;
    logic [CNT_W-1:0] wr_cnt;
    kpf_status_e      code;

    assign lk_set = lk_hash[SET_W-1:0];
    assign u_set  = upd_hash[SET_W-1:0];

    kpf_set_probe #(.WAYS(WAYS), .HASH_W(HASH_W), .CNT_W(CNT_W)) u_lk_probe (
        .tags(tag_q[lk_set]), .cnts(cnt_q[lk_set]), .key(lk_hash),
        .match_vec(lk_match_vec), .hit(lk_hit)
    );

    kpf_set_probe #(.WAYS(WAYS), .HASH_W(HASH_W), .CNT_W(CNT_W)) u_upd_probe (
        .tags(tag_q[u_set]), .cnts(cnt_q[u_set]), .key(upd_hash),
        .match_vec(u_match_vec), .hit(u_hit)
    );

    // encode the matching way and the lowest free way of the command's set
    always_comb begin
        u_hit_way  = '0;
        u_free     = 1'b0;
        u_free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (u_match_vec[w]) u_hit_way = WAY_W'(w);
            if (cnt_q[u_set][w] == '0) begin
                u_free     = 1'b1;
                u_free_way = WAY_W'(w);
            end
        end
    end

    assign u_hit_cnt = cnt_q[u_set][u_hit_way];

    // decide the write and the status for the current command
    always_comb begin
        wr_en  = 1'b0;
        wr_new = 1'b0;
        wr_way = u_hit_way;
        wr_cnt = u_hit_cnt;
        code   = ST_OK;
        if (upd_op == OP_INSERT) begin
            if (u_hit) begin
                if (u_hit_cnt == CNT_MAX) begin
                    code = ST_SAT;
                end else begin
                    wr_en  = 1'b1;
                    wr_cnt = u_hit_cnt + 1'b1;
                end
            end else if (u_free) begin
                wr_en  = 1'b1;
                wr_new = 1'b1;
                wr_way = u_free_way;
                wr_cnt = CNT_W'(1);
            end else begin
                code = ST_FULL;
            end
        end else begin
            if (u_hit) begin
                wr_en  = 1'b1;
                wr_cnt = u_hit_cnt - 1'b1;
            end else begin
                code = ST_ABSENT;
            end
        end
    end

    // reference counts: cleared by reset, written by accepted commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
        end else if (upd_valid && wr_en) begin
            cnt_q[u_set][wr_way] <= wr_cnt;
        end
    end

    // tags: written only when a new entry is allocated
    always_ff @(posedge clk) begin
        if (upd_valid && wr_new) tag_q[u_set][wr_way] <= upd_hash;
    end

    // status return one cycle after each command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_code  <= ST_OK;
        end else begin
            st_valid <= upd_valid;
            st_code  <= code;
        end
    end

    // R6: a hash is held by at most one live way of its set
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match_vec));

    // R5: a fresh entry starts with count 1 and is accepted
    a_r5_new_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_op == OP_INSERT && !u_hit && u_free) |=>
        (st_code == ST_OK && cnt_q[$past(u_set)][$past(u_free_way)] == CNT_W'(1)));

    // R6: a remove of a live hash lowers its count by one
    a_r6_remove_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_op == OP_REMOVE && u_hit) |=>
        (cnt_q[$past(u_set)][$past(u_hit_way)] == $past(u_hit_cnt) - 1'b1));

    // R7: a full set refuses and keeps all its counts
    a_r7_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_op == OP_INSERT && !u_hit && !u_free) |=>
        (st_code == ST_FULL && cnt_q[$past(u_set)] == $past(cnt_q[u_set])));

    // R8: a saturated count is reported and held
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_op == OP_INSERT && u_hit && u_hit_cnt == CNT_MAX) |=>
        (st_code == ST_SAT && cnt_q[$past(u_set)] == $past(cnt_q[u_set])));

    // R9: removing an absent hash is reported
    a_r9_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_op == OP_REMOVE && !u_hit) |=> (st_code == ST_ABSENT));

    // R12: status valid exactly one cycle after a command
    a_r12_status_on: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> st_valid);
    a_r12_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> !st_valid);
endmodule

// File: rtl/keyhash_presence_filter.sv
// Switch-side presence filter: rewrites in-network GET destinations to a
// synthetic MAC and steers hits to the accelerator; other packets bypass.
// Assumes: insert/remove commands come from completed accelerator work.
module keyhash_presence_filter #(
    parameter int SETS     = 256,
    parameter int WAYS     = 4,
    parameter int HASH_W   = 32,
    parameter int CNT_W    = 4,
    parameter int PREFIX_W = 16,
    parameter logic [PREFIX_W-1:0] MAC_PREFIX = 16'h02AA,
    localparam int MAC_W   = PREFIX_W + HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_in_net,
    input  logic [HASH_W-1:0] lk_hash,
    input  logic [MAC_W-1:0]  lk_dst_mac,
    output logic [MAC_W-1:0]  lk_out_mac,
    output logic              lk_to_accel,
    input  logic              upd_valid,
    input  logic              upd_op,
    input  logic [HASH_W-1:0] upd_hash,
    output logic              st_valid,
    output logic [1:0]        st_code
);
    logic lk_hit;

    kpf_table #(.SETS(SETS), .WAYS(WAYS), .HASH_W(HASH_W), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_hash(lk_hash), .lk_hit(lk_hit),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_hash(upd_hash),
        .st_valid(st_valid), .st_code(st_code)
    );

    // address rewrite only for in-network GETs, pass-through otherwise
    assign lk_out_mac  = lk_in_net ? {MAC_PREFIX, lk_hash} : lk_dst_mac;
    // steer to the accelerator only on a hit of an in-network GET
    assign lk_to_accel = lk_in_net & lk_hit;
endmodule

// File: tb/keyhash_presence_filter_test.sv
module keyhash_presence_filter_test;
    localparam int SETS = 4, WAYS = 2, HASH_W = 32, CNT_W = 2;
    localparam logic [15:0] PFX = 16'h02AA;
    localparam int CMAX = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_in_net = 1'b0;
    logic [31:0] lk_hash = '0;
    logic [47:0] lk_dst_mac = '0;
    logic [47:0] lk_out_mac;
    logic lk_to_accel;
    logic upd_valid = 1'b0, upd_op = 1'b0;
    logic [31:0] upd_hash = '0;
    logic st_valid;
    logic [1:0] st_code;

    int checks = 0, errors = 0;
    int mc [64];

    always #2 clk = ~clk;

    keyhash_presence_filter #(.SETS(SETS), .WAYS(WAYS), .HASH_W(HASH_W),
        .CNT_W(CNT_W), .MAC_PREFIX(PFX)) uut (
        .clk(clk), .rst_n(rst_n), .lk_in_net(lk_in_net), .lk_hash(lk_hash),
        .lk_dst_mac(lk_dst_mac), .lk_out_mac(lk_out_mac), .lk_to_accel(lk_to_accel),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_hash(upd_hash),
        .st_valid(st_valid), .st_code(st_code));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int mget(input logic [31:0] h);
        return (h < 64) ? mc[h] : 0;
    endfunction

    function automatic int occ(input int s);
        int n = 0;
        for (int g = 0; g < 64; g++) if (g % SETS == s && mc[g] > 0) n++;
        return n;
    endfunction

    // expected status from the requirement rules; also advances the model
    function automatic int predict(input bit op, input int h);
        if (!op) begin
            if (mc[h] > 0) begin
                if (mc[h] == CMAX) return 2;
                mc[h]++;
                return 0;
            end
            if (occ(h % SETS) < WAYS) begin mc[h] = 1; return 0; end
            return 1;
        end
        if (mc[h] > 0) begin mc[h]--; return 0; end
        return 3;
    endfunction

    // drive a lookup on the falling edge and check outputs combinationally
    task automatic look(input bit in_net, input logic [31:0] h, input logic [47:0] dst,
                        input string req);
        logic [47:0] emac;
        bit eacc;
        lk_in_net = in_net; lk_hash = h; lk_dst_mac = dst;
        #1;
        emac = in_net ? {PFX, h} : dst;
        eacc = in_net && (mget(h) > 0);
        chk(lk_out_mac == emac, req, "out_mac", lk_out_mac, emac);
        chk(lk_to_accel == eacc, req, "to_accel", lk_to_accel, eacc);
    endtask

    // one command in one cycle; status checked on the next falling edge
    task automatic cmd(input bit op, input int h, input string req);
        int es;
        @(negedge clk);
        upd_valid = 1'b1; upd_op = op; upd_hash = 32'(h);
        es = predict(op, h);
        @(negedge clk);
        upd_valid = 1'b0;
        chk(st_valid == 1'b1, "R12", "st_valid", st_valid, 1);
        chk(st_code == 2'(es), req, "st_code", st_code, es);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        errors++; checks++;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mc[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(st_valid == 1'b0, "R1", "st_valid in reset", st_valid, 0);
        look(1'b1, 32'd5, 48'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_valid == 1'b0, "R1", "st_valid after reset", st_valid, 0);
        look(1'b1, 32'd0, 48'h0, "R1");

        // R3: bypass leaves address untouched
        for (int i = 0; i < 8; i++)
            look(1'b0, 32'(i), 48'h1234_5600_0000 + 48'(i * 37), "R3");
        // R2: synthetic address for an in-network GET on a miss
        look(1'b1, 32'hDEAD_BEE0, 48'hFFFF_FFFF_FFFF, "R2");

        // R5, R7, R11: fill each set with two hashes, third is refused
        for (int h = 0; h < 12; h++) cmd(1'b0, h, (h < 8) ? "R5" : "R7");
        for (int h = 0; h < 16; h++) look(1'b1, 32'(h), 48'h0, "R11");
        // R4: tag compare uses full hash (same set index, high bits differ)
        look(1'b1, 32'h1000_0001, 48'h0, "R4");

        // R6, R8: count up to saturation on hash 1
        cmd(1'b0, 1, "R6");
        cmd(1'b0, 1, "R6");
        cmd(1'b0, 1, "R8");
        look(1'b1, 32'd1, 48'h0, "R8");
        for (int k = 0; k < 3; k++) begin
            cmd(1'b1, 1, "R6");
            look(1'b1, 32'd1, 48'h0, "R6");
        end
        // R9: remove of an absent hash
        cmd(1'b1, 1, "R9");
        cmd(1'b1, 40, "R9");
        look(1'b1, 32'd5, 48'h0, "R9");
        // R7: freed way is reusable
        cmd(1'b0, 9, "R5");
        cmd(1'b0, 13, "R7");
        look(1'b1, 32'd9, 48'h0, "R11");

        // R10: lookup in the same cycle as a remove sees pre-update state
        @(negedge clk);
        upd_valid = 1'b1; upd_op = 1'b1; upd_hash = 32'd0;
        look(1'b1, 32'd0, 48'h0, "R10");
        void'(predict(1'b1, 0));
        @(negedge clk);
        upd_valid = 1'b0;
        chk(st_code == 2'd0, "R10", "st_code", st_code, 0);
        look(1'b1, 32'd0, 48'h0, "R10");
        // R10: lookup in the same cycle as an insert
        @(negedge clk);
        upd_valid = 1'b1; upd_op = 1'b0; upd_hash = 32'd12;
        look(1'b1, 32'd12, 48'h0, "R10");
        void'(predict(1'b0, 12));
        @(negedge clk);
        upd_valid = 1'b0;
        chk(st_code == 2'd0, "R10", "st_code", st_code, 0);
        look(1'b1, 32'd12, 48'h0, "R10");
        @(negedge clk);
        chk(st_valid == 1'b0, "R12", "st_valid idle", st_valid, 0);

        // R4: final sweep against the model
        for (int h = 0; h < 64; h++) look(1'b1, 32'(h), 48'h0, "R4");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule